// File: doc/BRIEF.md
# ADC Conversion-Start and Read-Window Sequencer

This block drives the start line of an external serial ADC that is clocked from outside and gives no signal when a conversion ends. The rising edge of `conv_start` starts a conversion and puts the ADC's sampler into hold. The block then raises a one-cycle data-ready pulse once the conversion time has passed. Every duration is counted in system-clock cycles and set through a configuration load strobe.

Two waveform modes are available. In square-wave mode the high time is the conversion time, so the falling edge of `conv_start` coincides with the ready pulse. In narrow-pulse mode `conv_start` is only a short pulse, and the ready pulse comes after a separate ready delay counted from the rising edge.

A read-permit signal is open only while a serial read cannot disturb a conversion. It is closed while a conversion runs, and it is closed during a guard interval before the next rising edge. The block compares read requests against this permit and flags a read that is still in progress when the permit closes. After a channel-address write, the next rising edge is held back by an acquisition delay so that the new input can settle.

Top module: `adc_start_sequencer`

## Requirements
- R1: While `rst` is high and after it is released, `conv_start`, `rd_permit`, `rdy_irq`, `rd_grant`, `rd_refuse`, `overrun` and `cfg_err` are 0 and `viol_cnt` is 0. The first rising edge of `conv_start` appears exactly `DEF_LOW` cycles after the first clock edge with `rst` low.
- R2: With `cfg_narrow`=0 (square-wave mode), `conv_start` stays high for exactly the high time and low for exactly the low time, period after period.
- R3: In square-wave mode, `rdy_irq` is a one-cycle pulse in the same cycle in which `conv_start` first reads low.
- R4: With `cfg_narrow`=1 (narrow-pulse mode), `conv_start` stays high for the high time, and `rdy_irq` pulses exactly ready-delay cycles after the cycle in which `conv_start` rose.
- R5: `rd_permit` is 1 only when all three of these hold: `conv_start` is low and no acquisition delay is running; the conversion time since the last rising edge has elapsed; and more than the guard count of cycles remain before the next rising edge.
- R6: A `rd_req` sampled while `rd_permit` is 1 produces a one-cycle `rd_grant` in the next cycle. Otherwise `rd_refuse` pulses in the next cycle and `viol_cnt` increments, saturating at all ones.
- R7: If `rd_busy` is high in the first cycle in which `rd_permit` reads 0 after reading 1, `overrun` sets and stays set until reset. A read that ends while the permit is still open leaves `overrun` at 0.
- R8: A `chan_wr` pulse delays the next rising edge of `conv_start` by the acquisition count. Only that one edge is delayed.
- R9: A `cfg_load` with any of the following values sets the sticky `cfg_err`: a high time below `MIN_HIGH`; a zero low time; a zero ready delay in narrow mode; or a low time shorter than guard plus read length plus, in narrow mode, any excess of the ready delay over the high time. A later valid load does not clear `cfg_err`.
- R10: Values loaded with `cfg_load` take effect from the next phase. A phase that has already started keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Strobe that latches all cfg_* inputs |
| cfg_high | input | CNT_W | High time of conv_start in cycles |
| cfg_low | input | CNT_W | Low time of conv_start in cycles |
| cfg_rdy_dly | input | CNT_W | Narrow mode: cycles from rising edge to ready pulse |
| cfg_guard | input | CNT_W | Cycles before a rising edge in which reads are barred |
| cfg_rd_len | input | CNT_W | Length of one serial read, used only for the check |
| cfg_acq | input | CNT_W | Extra low cycles after a channel-address write |
| cfg_narrow | input | 1 | 1 = narrow-pulse mode, 0 = square-wave mode |
| chan_wr | input | 1 | Pulse marking a channel-address write |
| rd_req | input | 1 | Pulse requesting a serial read |
| rd_busy | input | 1 | High while a serial read is in progress |
| conv_start | output | 1 | Conversion-start line to the ADC |
| rdy_irq | output | 1 | One-cycle data-ready pulse |
| rd_permit | output | 1 | High while a read is safe |
| rd_grant | output | 1 | Pulse: last request accepted |
| rd_refuse | output | 1 | Pulse: last request refused |
| viol_cnt | output | VIOL_W | Saturating count of refused requests |
| overrun | output | 1 | Sticky: a read was still active when the permit closed |
| cfg_err | output | 1 | Sticky: a loaded configuration was unsafe |

## Verification
The hardest case to reach is an overrun. `rd_busy` must be held high across the single cycle in which the permit closes at the guard boundary, and that cycle lies a full period after reset. The bench works out this cycle from the reset time, the low time and the guard count. It raises `rd_busy` a few cycles before that cycle and releases it a few cycles after. It first runs a short read that ends early, to show that no overrun is flagged without cause. To reach the saturation of the violation counter, the bench sends hundreds of requests, each in a cycle where the permit is observed closed.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_LOW  = 2'd0,
    PH_ACQ  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Extra low-phase cycles that a narrow-pulse conversion still occupies
  function automatic int unsigned conv_spill(input int unsigned high_c,
                                             input int unsigned rdy_c,
                                             input logic narrow);
    if (narrow && (rdy_c > high_c)) return rdy_c - high_c;
    return 0;
  endfunction

  // True when a configuration leaves no room for a safe read
  function automatic logic cfg_is_bad(input int unsigned high_c,
                                      input int unsigned low_c,
                                      input int unsigned rdy_c,
                                      input int unsigned guard_c,
                                      input int unsigned rdlen_c,
                                      input logic narrow,
                                      input int unsigned min_high);
    logic bad;
    bad = (high_c < min_high) || (low_c == 0);
    if (narrow && (rdy_c == 0)) bad = 1'b1;
    if (low_c < guard_c + rdlen_c + conv_spill(high_c, rdy_c, narrow)) bad = 1'b1;
    return bad;
  endfunction

endpackage

// File: rtl/seq_cfg_regs.sv
module seq_cfg_regs
  import adc_seq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MIN_HIGH  = 4,
  parameter int DEF_HIGH  = 12,
  parameter int DEF_LOW   = 16,
  parameter int DEF_RDY   = 12,
  parameter int DEF_GUARD = 3,
  parameter int DEF_ACQ   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] in_high,
  input  logic [CNT_W-1:0] in_low,
  input  logic [CNT_W-1:0] in_rdy,
  input  logic [CNT_W-1:0] in_guard,
  input  logic [CNT_W-1:0] in_rd_len,
  input  logic [CNT_W-1:0] in_acq,
  input  logic             in_narrow,
  output logic [CNT_W-1:0] high_q,
  output logic [CNT_W-1:0] low_q,
  output logic [CNT_W-1:0] rdy_q,
  output logic [CNT_W-1:0] guard_q,
  output logic [CNT_W-1:0] acq_q,
  output logic             narrow_q,
  output logic             cfg_err
);

  logic load_bad;

  always_comb begin
    load_bad = cfg_is_bad(32'(in_high), 32'(in_low), 32'(in_rdy), 32'(in_guard),
                          32'(in_rd_len), in_narrow, 32'(MIN_HIGH));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      high_q   <= CNT_W'(DEF_HIGH);
      low_q    <= CNT_W'(DEF_LOW);
      rdy_q    <= CNT_W'(DEF_RDY);
      guard_q  <= CNT_W'(DEF_GUARD);
      acq_q    <= CNT_W'(DEF_ACQ);
      narrow_q <= 1'b0;
      cfg_err  <= 1'b0;
    end else if (cfg_load) begin
      high_q   <= in_high;
      low_q    <= in_low;
      rdy_q    <= in_rdy;
      guard_q  <= in_guard;
      acq_q    <= in_acq;
      narrow_q <= in_narrow;
      cfg_err  <= cfg_err | load_bad;
    end
  end

  assert_cfg_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_err) |-> cfg_err);

endmodule

// File: rtl/seq_phase_ctrl.sv
module seq_phase_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RST_LOW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] high_len,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] acq_len,
  input  logic             chan_wr,
  output phase_e           phase,
  output logic [CNT_W-1:0] ph_remain,
  output logic             start_edge
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             last_cyc;
  logic             low_done;

  always_comb begin
    last_cyc = (cnt_q <= ONE);
    ph_d     = ph_q;
    cnt_d    = cnt_q - ONE;
    case (ph_q)
      PH_LOW: begin
        if (last_cyc) begin
          if (pend_q && (acq_len != '0)) begin
            ph_d  = PH_ACQ;
            cnt_d = acq_len;
          end else begin
            ph_d  = PH_HIGH;
            cnt_d = high_len;
          end
        end
      end
      PH_ACQ: begin
        if (last_cyc) begin
          ph_d  = PH_HIGH;
          cnt_d = high_len;
        end
      end
      PH_HIGH: begin
        if (last_cyc) begin
          ph_d  = PH_LOW;
          cnt_d = low_len;
        end
      end
      default: begin
        ph_d  = PH_LOW;
        cnt_d = low_len;
      end
    endcase
    low_done   = (ph_q == PH_LOW) && last_cyc;
    pend_d     = chan_wr | (pend_q & ~low_done);
    start_edge = (ph_d == PH_HIGH) && (ph_q != PH_HIGH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_LOW;
      cnt_q  <= CNT_W'(RST_LOW);
      pend_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign phase     = ph_q;
  assign ph_remain = cnt_q;

  assert_acq_needs_write_R8: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_ACQ && $past(ph_q) == PH_LOW) |-> $past(pend_q));

  assert_high_not_from_high_R2: assert property (@(posedge clk) disable iff (rst)
    start_edge |=> (ph_q == PH_HIGH && $past(ph_q) != PH_HIGH));

endmodule

// File: rtl/seq_conv_timer.sv
module seq_conv_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_edge,
  input  logic             narrow,
  input  logic [CNT_W-1:0] high_len,
  input  logic [CNT_W-1:0] rdy_len,
  output logic             conv_busy,
  output logic             rdy_irq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] conv_cnt;
  logic [CNT_W-1:0] conv_len;
  logic             irq_q;

  always_comb begin
    conv_len = narrow ? rdy_len : high_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_cnt <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= (conv_cnt == ONE);
      if (start_edge)            conv_cnt <= conv_len;
      else if (conv_cnt != '0)   conv_cnt <= conv_cnt - ONE;
    end
  end

  assign conv_busy = (conv_cnt != '0);
  assign rdy_irq   = irq_q;

  assert_irq_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    rdy_irq |=> !rdy_irq);

endmodule

// File: rtl/seq_read_guard.sv
module seq_read_guard
  import adc_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int VIOL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase,
  input  logic [CNT_W-1:0]  ph_remain,
  input  logic [CNT_W-1:0]  guard_len,
  input  logic              conv_busy,
  input  logic              rd_req,
  input  logic              rd_busy,
  output logic              rd_permit,
  output logic              rd_grant,
  output logic              rd_refuse,
  output logic [VIOL_W-1:0] viol_cnt,
  output logic              overrun
);

  localparam logic [VIOL_W-1:0] VIOL_MAX = '1;

  function automatic logic [VIOL_W-1:0] sat_inc(input logic [VIOL_W-1:0] v);
    return (v == VIOL_MAX) ? v : v + VIOL_W'(1);
  endfunction

  logic permit_c, permit_q, close_ev;
  logic grant_q, refuse_q, ovr_q;
  logic [VIOL_W-1:0] viol_q;

  always_comb begin
    permit_c = !rst && (phase == PH_LOW) && !conv_busy && (ph_remain > guard_len);
    close_ev = permit_q && !permit_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      permit_q <= 1'b0;
      grant_q  <= 1'b0;
      refuse_q <= 1'b0;
      viol_q   <= '0;
      ovr_q    <= 1'b0;
    end else begin
      permit_q <= permit_c;
      grant_q  <= rd_req && permit_c;
      refuse_q <= rd_req && !permit_c;
      if (rd_req && !permit_c) viol_q <= sat_inc(viol_q);
      ovr_q    <= ovr_q | (close_ev & rd_busy);
    end
  end

  assign rd_permit = permit_c;
  assign rd_grant  = grant_q;
  assign rd_refuse = refuse_q;
  assign viol_cnt  = viol_q;
  assign overrun   = ovr_q;

  assert_grant_in_window_R6: assert property (@(posedge clk) disable iff (rst)
    rd_grant |-> $past(rd_permit) && $past(rd_req));

  assert_viol_counts_R6: assert property (@(posedge clk) disable iff (rst)
    rd_refuse |-> (viol_cnt == $past(viol_cnt) + 1'b1) || (viol_cnt == VIOL_MAX));

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $past(overrun) |-> overrun);

endmodule

// File: rtl/adc_start_sequencer.sv
module adc_start_sequencer
  import adc_seq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int VIOL_W    = 8,
  parameter int MIN_HIGH  = 4,
  parameter int DEF_HIGH  = 12,
  parameter int DEF_LOW   = 16,
  parameter int DEF_RDY   = 12,
  parameter int DEF_GUARD = 3,
  parameter int DEF_ACQ   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [CNT_W-1:0]  cfg_high,
  input  logic [CNT_W-1:0]  cfg_low,
  input  logic [CNT_W-1:0]  cfg_rdy_dly,
  input  logic [CNT_W-1:0]  cfg_guard,
  input  logic [CNT_W-1:0]  cfg_rd_len,
  input  logic [CNT_W-1:0]  cfg_acq,
  input  logic              cfg_narrow,
  input  logic              chan_wr,
  input  logic              rd_req,
  input  logic              rd_busy,
  output logic              conv_start,
  output logic              rdy_irq,
  output logic              rd_permit,
  output logic              rd_grant,
  output logic              rd_refuse,
  output logic [VIOL_W-1:0] viol_cnt,
  output logic              overrun,
  output logic              cfg_err
);

  logic [CNT_W-1:0] high_q, low_q, rdy_q, guard_q, acq_q;
  logic             narrow_q;
  phase_e           phase;
  logic [CNT_W-1:0] ph_remain;
  logic             start_edge;
  logic             conv_busy;

  seq_cfg_regs #(
    .CNT_W(CNT_W), .MIN_HIGH(MIN_HIGH), .DEF_HIGH(DEF_HIGH), .DEF_LOW(DEF_LOW),
    .DEF_RDY(DEF_RDY), .DEF_GUARD(DEF_GUARD), .DEF_ACQ(DEF_ACQ)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_load(cfg_load),
    .in_high(cfg_high), .in_low(cfg_low), .in_rdy(cfg_rdy_dly),
    .in_guard(cfg_guard), .in_rd_len(cfg_rd_len), .in_acq(cfg_acq),
    .in_narrow(cfg_narrow),
    .high_q(high_q), .low_q(low_q), .rdy_q(rdy_q), .guard_q(guard_q),
    .acq_q(acq_q), .narrow_q(narrow_q), .cfg_err(cfg_err)
  );

  seq_phase_ctrl #(.CNT_W(CNT_W), .RST_LOW(DEF_LOW)) u_phase (
    .clk(clk), .rst(rst), .high_len(high_q), .low_len(low_q), .acq_len(acq_q),
    .chan_wr(chan_wr), .phase(phase), .ph_remain(ph_remain), .start_edge(start_edge)
  );

  seq_conv_timer #(.CNT_W(CNT_W)) u_conv (
    .clk(clk), .rst(rst), .start_edge(start_edge), .narrow(narrow_q),
    .high_len(high_q), .rdy_len(rdy_q), .conv_busy(conv_busy), .rdy_irq(rdy_irq)
  );

  seq_read_guard #(.CNT_W(CNT_W), .VIOL_W(VIOL_W)) u_guard (
    .clk(clk), .rst(rst), .phase(phase), .ph_remain(ph_remain), .guard_len(guard_q),
    .conv_busy(conv_busy), .rd_req(rd_req), .rd_busy(rd_busy),
    .rd_permit(rd_permit), .rd_grant(rd_grant), .rd_refuse(rd_refuse),
    .viol_cnt(viol_cnt), .overrun(overrun)
  );

  assign conv_start = (phase == PH_HIGH);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !conv_start && !overrun && !cfg_err && (viol_cnt == '0));

  assert_square_irq_at_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (!narrow_q && $fell(conv_start)) |-> rdy_irq);

  assert_no_permit_while_high_R5: assert property (@(posedge clk) disable iff (rst)
    rd_permit |-> !conv_start && !conv_busy);

  assert_no_permit_before_edge_R5: assert property (@(posedge clk) disable iff (rst)
    start_edge |-> !rd_permit || (guard_q == '0));

endmodule

// File: tb/test_adc_start_sequencer.sv
`timescale 1ns/1ps
module test_adc_start_sequencer;

  localparam int W  = 16;
  localparam int VW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1, cfg_load = 1'b0, cfg_narrow = 1'b0;
  logic [W-1:0]  cfg_high, cfg_low, cfg_rdy_dly, cfg_guard, cfg_rd_len, cfg_acq;
  logic          chan_wr = 1'b0, rd_req = 1'b0, rd_busy = 1'b0;
  logic          conv_start, rdy_irq, rd_permit, rd_grant, rd_refuse, overrun, cfg_err;
  logic [VW-1:0] viol_cnt;

  adc_start_sequencer i_adc_start_sequencer (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_high(cfg_high), .cfg_low(cfg_low),
    .cfg_rdy_dly(cfg_rdy_dly), .cfg_guard(cfg_guard), .cfg_rd_len(cfg_rd_len),
    .cfg_acq(cfg_acq), .cfg_narrow(cfg_narrow), .chan_wr(chan_wr), .rd_req(rd_req),
    .rd_busy(rd_busy), .conv_start(conv_start), .rdy_irq(rdy_irq), .rd_permit(rd_permit),
    .rd_grant(rd_grant), .rd_refuse(rd_refuse), .viol_cnt(viol_cnt), .overrun(overrun),
    .cfg_err(cfg_err)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int exp_q[$];
  bit mon_en = 0, pm_en = 0;
  logic prev_cs = 1'b0;
  int t0;
  int sc_t0, sc_l0, sc_h, sc_l, sc_d, sc_g;
  bit sc_nar;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic set_defaults();
    cfg_high = 12; cfg_low = 16; cfg_rdy_dly = 12; cfg_guard = 3;
    cfg_rd_len = 6; cfg_acq = 5; cfg_narrow = 1'b0;
  endtask

  // Expected permit from the requirements, as a function of cycle number
  function automatic bit exp_permit(input int t);
    int p, rem;
    if (t < sc_t0 + sc_l0) begin
      rem = sc_t0 + sc_l0 - t;
      return rem > sc_g;
    end
    p = (t - sc_t0 - sc_l0) % (sc_h + sc_l);
    if (p < sc_h) return 0;
    if (sc_nar && p < sc_d) return 0;
    rem = sc_h + sc_l - p;
    return rem > sc_g;
  endfunction

  // Driver: expected edges, encoded as cycle*4 + kind (0 rise, 1 fall, 2 ready)
  task automatic push_timeline(input int base, input int l0, input int acq0, input int h,
                               input int l, input int d, input bit nar, input int n);
    int r = base + l0 + acq0;
    for (int k = 0; k < n; k++) begin
      int f = r + h;
      int i = nar ? r + d : r + h;
      exp_q.push_back(r * 4);
      if (i < f) begin
        exp_q.push_back(i * 4 + 2);
        exp_q.push_back(f * 4 + 1);
      end else begin
        exp_q.push_back(f * 4 + 1);
        exp_q.push_back(i * 4 + 2);
      end
      r = r + h + l;
    end
  endtask

  task automatic sb_pop(input int kind);
    int e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R2", "unexpected edge kind", kind, -1);
    end else begin
      e = exp_q.pop_front();
      if (kind == 0)      check(e == cyc * 4, "R1/R2", "rise cycle*4", cyc * 4, e);
      else if (kind == 1) check(e == cyc * 4 + 1, "R2/R4", "fall cycle*4+1", cyc * 4 + 1, e);
      else                check(e == cyc * 4 + 2, "R3/R4", "ready cycle*4+2", cyc * 4 + 2, e);
    end
  endtask

  // Monitor: pops the scoreboard as edges appear; also compares the permit window
  always @(negedge clk) begin
    if (mon_en) begin
      if (conv_start && !prev_cs) sb_pop(0);
      if (!conv_start && prev_cs) sb_pop(1);
      if (rdy_irq) sb_pop(2);
    end
    if (pm_en) check(rd_permit == exp_permit(cyc), "R5", "permit window",
                     int'(rd_permit), int'(exp_permit(cyc)));
    prev_cs = conv_start;
  end

  task automatic do_reset();
    rst = 1'b1; cfg_load = 1'b0; chan_wr = 1'b0; rd_req = 1'b0; rd_busy = 1'b0;
    set_defaults();
    repeat (4) @(negedge clk);
    check(!conv_start && !rd_permit && !rdy_irq && !rd_grant && !rd_refuse,
          "R1", "outputs in reset", int'(conv_start | rd_permit | rdy_irq), 0);
    check(!overrun && !cfg_err && viol_cnt == 0, "R1", "flags in reset",
          int'(viol_cnt) + int'(overrun) + int'(cfg_err), 0);
    rst = 1'b0;
    t0 = cyc;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic run_sb(input string req);
    for (int k = 0; k < 400 && exp_q.size() != 0; k++) @(negedge clk);
    check(exp_q.size() == 0, req, "edges left in scoreboard", exp_q.size(), 0);
    mon_en = 0; pm_en = 0;
    exp_q.delete();
  endtask

  task automatic set_scen(input int l0, input int h, input int l, input int d,
                          input int g, input bit nar);
    sc_t0 = t0; sc_l0 = l0; sc_h = h; sc_l = l; sc_d = d; sc_g = g; sc_nar = nar;
  endtask

  initial begin
    int sent;
    set_defaults();

    // S1: square wave with defaults; first rise one low time after reset (R1, R2, R3, R5)
    do_reset();
    set_scen(16, 12, 16, 12, 3, 0);
    push_timeline(t0, 16, 0, 12, 16, 12, 0, 3);
    @(negedge clk);
    mon_en = 1; pm_en = 1;
    run_sb("R2");

    // S2: narrow pulse loaded just after reset; first low keeps its length (R4, R10, R5)
    do_reset();
    cfg_high = 8; cfg_low = 20; cfg_rdy_dly = 14; cfg_guard = 2; cfg_rd_len = 4;
    cfg_narrow = 1'b1; cfg_load = 1'b1;
    set_scen(16, 8, 20, 14, 2, 1);
    push_timeline(t0, 16, 0, 8, 20, 14, 1, 3);
    @(negedge clk);
    cfg_load = 1'b0;
    mon_en = 1; pm_en = 1;
    run_sb("R10");
    check(cfg_err == 1'b0, "R9", "valid narrow config error flag", int'(cfg_err), 0);

    // S3: channel write delays only the next rise by the acquisition count (R8)
    do_reset();
    push_timeline(t0, 16, 5, 12, 16, 12, 0, 2);
    @(negedge clk);
    mon_en = 1;
    @(negedge clk);
    chan_wr = 1'b1;
    @(negedge clk);
    chan_wr = 1'b0;
    run_sb("R8");

    // S4: grant, guard boundary, refusal and saturation (R5, R6)
    do_reset();
    @(negedge clk);
    check(rd_permit == 1'b1, "R5", "permit open early in low", int'(rd_permit), 1);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check(rd_grant == 1'b1 && rd_refuse == 1'b0, "R6", "grant inside window", int'(rd_grant), 1);
    check(viol_cnt == 0, "R6", "no violation on grant", int'(viol_cnt), 0);
    wait_to(t0 + 12);
    check(rd_permit == 1'b1, "R5", "permit with guard+1 left", int'(rd_permit), 1);
    @(negedge clk);
    check(rd_permit == 1'b0, "R5", "permit with guard left", int'(rd_permit), 0);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check(rd_refuse == 1'b1 && rd_grant == 1'b0, "R6", "refuse in guard", int'(rd_refuse), 1);
    check(viol_cnt == 1, "R6", "violation count", int'(viol_cnt), 1);
    sent = 1;
    while (sent < 300) begin
      @(negedge clk);
      if (!rd_permit) begin rd_req = 1'b1; sent++; end
      else rd_req = 1'b0;
    end
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
    check(viol_cnt == 255, "R6", "violation count saturates", int'(viol_cnt), 255);

    // S5: short read ends inside window; long read spans the close (R7)
    do_reset();
    @(negedge clk);
    rd_busy = 1'b1;
    repeat (4) @(negedge clk);
    rd_busy = 1'b0;
    wait_to(t0 + 20);
    check(overrun == 1'b0, "R7", "no overrun for early-ending read", int'(overrun), 0);
    wait_to(t0 + 35);
    rd_busy = 1'b1;
    wait_to(t0 + 41);
    check(rd_permit == 1'b0, "R5", "window closed at guard", int'(rd_permit), 0);
    wait_to(t0 + 43);
    rd_busy = 1'b0;
    check(overrun == 1'b1, "R7", "overrun on read across close", int'(overrun), 1);
    repeat (30) @(negedge clk);
    check(overrun == 1'b1, "R7", "overrun sticky", int'(overrun), 1);

    // S6: unsafe configurations (R9); reset clears the flag (R1)
    do_reset();
    cfg_low = 5; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    check(cfg_err == 1'b1, "R9", "low too short for guard+read", int'(cfg_err), 1);
    set_defaults(); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    check(cfg_err == 1'b1, "R9", "valid load keeps sticky flag", int'(cfg_err), 1);
    do_reset();
    cfg_high = 2; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    check(cfg_err == 1'b1, "R9", "high below minimum", int'(cfg_err), 1);
    do_reset();
    cfg_narrow = 1'b1; cfg_high = 8; cfg_rdy_dly = 16; cfg_low = 16; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    check(cfg_err == 1'b1, "R9", "narrow spill leaves no window", int'(cfg_err), 1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule